// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier Unit

This unit forms integer products from one shared signed multiplier array. Each operand is widened by one bit before it reaches the array. The extra bit copies the sign bit when the operand is treated as signed and is zero when it is treated as unsigned. Because of this, one (OPW+1)-bit two's-complement array computes signed, unsigned and mixed-sign products, products against a small zero-extended immediate literal, and a narrow unsigned byte product.

A caller presents two OPW-bit operands, an LITW-bit literal and a 3-bit mode code, and pulses `in_valid`. One clock later the 2·OPW-bit product is held in a register and `out_valid` is high for that cycle. The product keeps its value until the next accepted request. The result is the low 2·OPW bits of the array output, and this is exact for every mode.

Top module: `mixmul_unit`

## Requirements
- R1: Mode code 0 multiplies `opa` and `opb`, both taken as signed two's-complement numbers, and returns the exact signed product.
- R2: Mode code 1 multiplies `opa` and `opb`, both taken as unsigned numbers, and returns the exact unsigned product.
- R3: Mode code 2 takes `opa` as unsigned and `opb` as signed, and returns the exact two's-complement product.
- R4: Mode code 3 takes `opa` as signed and `opb` as unsigned, and returns the exact two's-complement product.
- R5: Mode code 4 multiplies signed `opa` by `lit`, where `lit` is zero-extended and so never negative. `opb` is ignored.
- R6: Mode code 5 multiplies unsigned `opa` by the zero-extended `lit`. The product never exceeds OPW+LITW significant bits, and `opb` is ignored.
- R7: Mode code 6 multiplies the low NARW bits of `opa` by the low NARW bits of `opb`, both unsigned. The upper operand bits are ignored, and every product bit at position 2·NARW or above is zero.
- R8: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and in no other cycle.
- R9: While `in_valid` is low, `product` keeps its value whatever the other inputs do.
- R10: Mode code 7 is reserved. An accepted request with this code stores a product of zero.
- R11: While `rst_n` is low, `product` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are sampled on this cycle |
| mode | input | 3 | Mode code (0..7, see requirements) |
| opa | input | OPW | First operand |
| opb | input | OPW | Second operand |
| lit | input | LITW | Immediate literal, always unsigned |
| out_valid | output | 1 | High for one cycle per accepted request |
| product | output | 2·OPW | Registered product |

## Verification
The bench builds the unit with OPW=6, LITW=3, NARW=4 and the partial-product array variant (ARRAY_STYLE=1). At this size every operand pair for all four 16-bit-style signedness modes can be applied, along with every operand and literal pair for both literal modes and all operand values in byte mode, including the most negative value times itself and the all-ones unsigned corner. The small literal and narrow widths also make it cheap to show that ignored operand bits never leak into the product.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;

   typedef enum logic [2:0] {
      MM_SS  = 3'd0,
      MM_UU  = 3'd1,
      MM_US  = 3'd2,
      MM_SU  = 3'd3,
      MM_SL  = 3'd4,
      MM_UL  = 3'd5,
      MM_NB  = 3'd6,
      MM_RSV = 3'd7
   } mm_mode_e;

   localparam int MM_STYLE_INFER = 0;
   localparam int MM_STYLE_PPSUM = 1;

endpackage

// File: rtl/mixmul_extend.sv
module mixmul_extend #(
   parameter int W = 16
) (
   input  logic [W-1:0] val,
   input  logic         sgn,
   output logic [W:0]   ext
);

   if (W < 1) begin : g_bad_w
      $error("mixmul_extend: W must be at least 1");
   end

   assign ext = {sgn & val[W-1], val};

endmodule

// File: rtl/mixmul_array.sv
module mixmul_array
   import mixmul_pkg::*;
#(
   parameter int W     = 17,
   parameter int STYLE = MM_STYLE_INFER
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);

   localparam int PW = 2 * W;

   logic [PW-1:0] a_wide;
   assign a_wide = {{W{a[W-1]}}, a};

   if (W < 2) begin : g_bad_w
      $error("mixmul_array: W must be at least 2");
   end

   if (STYLE == MM_STYLE_INFER) begin : g_infer
      logic signed [PW-1:0] as_w;
      logic signed [PW-1:0] bs_w;
      assign as_w = $signed(a_wide);
      assign bs_w = $signed({{W{b[W-1]}}, b});
      assign p    = as_w * bs_w;
   end else if (STYLE == MM_STYLE_PPSUM) begin : g_ppsum
      logic [PW-1:0] pp [W];
      for (genvar i = 0; i < W; i++) begin : g_row
         if (i < W - 1) begin : g_pos
            assign pp[i] = b[i] ? (a_wide << i) : '0;
         end else begin : g_neg
            assign pp[i] = b[i] ? (~(a_wide << i) + PW'(1)) : '0;
         end
      end
      always_comb begin
         p = '0;
         for (int k = 0; k < W; k++) begin
            p = p + pp[k];
         end
      end
   end else begin : g_bad_style
      $error("mixmul_array: unknown STYLE");
   end

endmodule

// File: rtl/mixmul_unit.sv
module mixmul_unit
   import mixmul_pkg::*;
#(
   parameter int OPW         = 16,
   parameter int LITW        = 5,
   parameter int NARW        = 8,
   parameter int ARRAY_STYLE = MM_STYLE_INFER
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        mode,
   input  logic [OPW-1:0]    opa,
   input  logic [OPW-1:0]    opb,
   input  logic [LITW-1:0]   lit,
   output logic              out_valid,
   output logic [2*OPW-1:0]  product
);

   localparam int EXTW  = OPW + 1;
   localparam int PRODW = 2 * OPW;
   localparam int ARRW  = 2 * EXTW;
   localparam int LBND  = OPW + LITW;
   localparam int NBND  = 2 * NARW;

   if (OPW < 2) begin : g_chk_opw
      $error("mixmul_unit: OPW must be at least 2");
   end
   if (LITW < 1 || LITW >= OPW) begin : g_chk_litw
      $error("mixmul_unit: LITW must lie in 1..OPW-1");
   end
   if (NARW < 1 || NARW > OPW) begin : g_chk_narw
      $error("mixmul_unit: NARW must lie in 1..OPW");
   end

   mm_mode_e mode_e;
   assign mode_e = mm_mode_e'(mode);

   logic [OPW-1:0] a_val, b_val;
   logic           a_sgn, b_sgn;

   always_comb begin
      a_val = opa;
      b_val = opb;
      a_sgn = 1'b0;
      b_sgn = 1'b0;
      case (mode_e)
         MM_SS: begin a_sgn = 1'b1; b_sgn = 1'b1; end
         MM_US: b_sgn = 1'b1;
         MM_SU: a_sgn = 1'b1;
         MM_SL: begin a_sgn = 1'b1; b_val = OPW'(lit); end
         MM_UL: b_val = OPW'(lit);
         MM_NB: begin
            a_val = OPW'(opa[NARW-1:0]);
            b_val = OPW'(opb[NARW-1:0]);
         end
         default: ;
      endcase
   end

   logic [EXTW-1:0] a_ext, b_ext;
   logic [ARRW-1:0] arr_out;
   logic [PRODW-1:0] result;

   mixmul_extend #(.W(OPW)) u_ext_a (.val(a_val), .sgn(a_sgn), .ext(a_ext));
   mixmul_extend #(.W(OPW)) u_ext_b (.val(b_val), .sgn(b_sgn), .ext(b_ext));

   mixmul_array #(.W(EXTW), .STYLE(ARRAY_STYLE)) u_array (
      .a(a_ext),
      .b(b_ext),
      .p(arr_out)
   );

   assign result = (mode_e == MM_RSV) ? '0 : arr_out[PRODW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         product   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            product <= result;
         end
      end
   end

   AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);  // R8
   AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);  // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(product));  // R9
   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_e == MM_NB) |=> (product >> NBND) == '0);  // R7
   AST_LIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_e == MM_UL) |=> (product >> LBND) == '0);  // R6
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_e == MM_RSV) |=> product == '0);  // R10

endmodule

// File: tb/mixmul_unit_test.sv
module mixmul_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int OPW  = 6;
   localparam int LITW = 3;
   localparam int NARW = 4;
   localparam int PW   = 2 * OPW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [2:0]      mode = 3'd0;
   logic [OPW-1:0]  opa = '0;
   logic [OPW-1:0]  opb = '0;
   logic [LITW-1:0] lit = '0;
   logic            out_valid;
   logic [PW-1:0]   product;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mixmul_unit #(.OPW(OPW), .LITW(LITW), .NARW(NARW), .ARRAY_STYLE(1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .opa(opa), .opb(opb), .lit(lit),
      .out_valid(out_valid), .product(product)
   );

   function automatic longint sval(input longint v, input int w);
      return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
   endfunction

   function automatic logic [PW-1:0] expect_prod(input int m, input longint a,
                                                 input longint b, input longint l);
      longint x, y, nm;
      nm = (longint'(1) << NARW) - 1;
      case (m)
         0: begin x = sval(a, OPW); y = sval(b, OPW); end
         1: begin x = a;            y = b;            end
         2: begin x = a;            y = sval(b, OPW); end
         3: begin x = sval(a, OPW); y = b;            end
         4: begin x = sval(a, OPW); y = l;            end
         5: begin x = a;            y = l;            end
         6: begin x = a & nm;       y = b & nm;       end
         default: begin x = 0; y = 0; end
      endcase
      return PW'(x * y);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input int m, input int a, input int b, input int l,
                        input string req);
      mode     = 3'(m);
      opa      = OPW'(a);
      opb      = OPW'(b);
      lit      = LITW'(l);
      in_valid = 1'b1;
      @(negedge clk);
      check(req, longint'(product), longint'(expect_prod(m, a, b, l)));
      if (out_valid !== 1'b1) begin
         check("R8 out_valid", 0, 1);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      string tags [7] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7"};
      logic [PW-1:0] held;
      repeat (3) @(negedge clk);
      check("R11 product in reset", longint'(product), 0);
      check("R11 out_valid in reset", longint'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle out_valid", longint'(out_valid), 0);

      for (int m = 0; m < 4; m++)
         for (int a = 0; a < (1 << OPW); a++)
            for (int b = 0; b < (1 << OPW); b++)
               apply(m, a, b, (a + b) & 7, tags[m]);

      for (int m = 4; m < 6; m++)
         for (int a = 0; a < (1 << OPW); a++)
            for (int l = 0; l < (1 << LITW); l++)
               apply(m, a, (a * 7 + l) & 63, l, tags[m]);

      for (int a = 0; a < (1 << OPW); a++)
         for (int b = 0; b < (1 << OPW); b++)
            apply(6, a, b, 0, "R7");

      apply(7, 63, 63, 7, "R10");
      apply(7, 32, 17, 3, "R10");

      apply(0, 32, 32, 0, "R1");
      held = product;
      in_valid = 1'b0;
      mode = 3'd1;
      opa = 6'd63;
      opb = 6'd63;
      @(negedge clk);
      check("R8 out_valid drop", longint'(out_valid), 0);
      check("R9 hold", longint'(product), longint'(held));
      opa = 6'd5;
      lit = 3'd6;
      mode = 3'd5;
      @(negedge clk);
      check("R9 hold", longint'(product), longint'(held));

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule